// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a simple on-chip request port and an asynchronous static RAM. It takes one single-word read or write at a time and produces the strobe pattern the RAM needs. The RAM has an active-low chip enable, an active-high chip enable, an active-low write strobe and an active-low output enable. The minimum intervals of the RAM are given as nanosecond parameters, together with the clock period. The controller converts each interval to a whole number of clock cycles and holds every phase of the access for at least that long.

A write takes effect only while both enables are active and the write strobe is low. Write data and address must be valid well before the write strobe rises, and must stay valid past that edge. The controller therefore sets up the address, the enables and the data one cycle before it lowers the write strobe, and keeps them unchanged for a recovery phase after the strobe rises. For a read, the controller enables the RAM and lowers the output enable, then samples the data bus at the clock edge that ends the access phase. The result is returned with a one-cycle done pulse. Whenever the direction changes between two accesses, a turnaround phase with every strobe inactive and the data bus undriven lets the previous driver float first.

The FSM states are IDLE, TURN, WR_SETUP, WR_PULSE, WR_RECOV and RD_ACCESS. The transitions are:
- IDLE to TURN when a request of the other direction is accepted.
- IDLE to WR_SETUP or to RD_ACCESS when a request of the same direction is accepted.
- TURN to WR_SETUP or to RD_ACCESS when the turnaround count expires.
- WR_SETUP to WR_PULSE after one cycle.
- WR_PULSE to WR_RECOV when the pulse count expires.
- WR_RECOV to IDLE, and RD_ACCESS to IDLE, when their counts expire.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, `sram_ce_n` is 1, `sram_ce` is 0, `sram_we_n` is 1, `sram_oe_n` is 1, `sram_dq_oe` is 0 and `rsp_done` is 0.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in IDLE, so only one access is in flight at a time. While the controller is in IDLE, both enables are inactive.
- R3: Each phase lasts a number of cycles derived from the parameters: c(t) = max(1, ceil(t / CLK_PERIOD_NS)). The counts are:
  - N_TA = max(c(OE float), c(WE float)).
  - N_WP = max(c(WE pulse), c(data setup), c(address setup)).
  - N_WR = max(1, c(cycle) - 1 - N_WP).
  - N_RA = max(c(address access), c(OE access), c(cycle)).
  With the defaults these are 1, 2, 1 and 2.
- R4: A write runs in three phases:
  - One setup cycle with both enables active, the address and data driven, `sram_dq_oe` = 1 and `sram_we_n` = 1.
  - N_WP cycles with `sram_we_n` = 0.
  - N_WR recovery cycles with `sram_we_n` = 1, while the enables, address and data stay unchanged.
- R5: `sram_we_n` is 0 only while `sram_ce_n` = 0, `sram_ce` = 1 and `sram_oe_n` = 1.
- R6: A read holds both enables active and `sram_oe_n` = 0 for N_RA cycles, with the data bus undriven. `sram_dq_in` is captured at the clock edge that ends the last of these cycles.
- R7: `rsp_done` is 1 for exactly the one cycle after the last strobe cycle of each access, read or write. `req_ready` is 1 in that same cycle.
- R8: When an accepted request has the other direction from the previous access, N_TA cycles with both enables inactive, `sram_we_n` = `sram_oe_n` = 1 and `sram_dq_oe` = 0 come before its first phase. The state after reset counts as a read.
- R9: `sram_dq_oe` is never 1 while `sram_oe_n` is 0, and a rise of `sram_dq_oe` always follows a cycle with `sram_oe_n` = 1.
- R10: `rsp_rdata` at a read's done pulse equals the data most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| sram_addr | output | ADDR_W | RAM address |
| sram_dq_out | output | DATA_W | Data toward the RAM |
| sram_dq_in | input | DATA_W | Data from the RAM |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |

## Verification
Some properties are checked by assertions on every cycle:
- The write strobe is gated by both enables and a high output enable.
- The write strobe stays low for at least N_WP cycles.
- Address, data and enables are frozen across the rising edge of the write strobe.
- The data bus is never driven against a low output enable.
- The done pulse lasts a single cycle.

Other behaviour only the bench scenarios can show:
- The exact cycle length of each phase.
- The turnaround inserted only on a change of direction.
- The point at which read data is sampled.
- That data written at random addresses, including the first and last address, reads back intact.

The bench's RAM model returns a poison value until both read intervals have passed, so sampling too early shows up as bad data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_RD_ACCESS
    } ctrl_state_t;

    // whole clock cycles covering a nanosecond minimum, never fewer than one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/req_latch.sv
module req_latch #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          in_write,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    output logic          out_write,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_wdata
);
    // out_write also remembers the direction of the previous access;
    // reset leaves it at "read"
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_write <= 1'b0;
            out_addr  <= '0;
            out_wdata <= '0;
        end else if (take) begin
            out_write <= in_write;
            out_addr  <= in_addr;
            out_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/rsp_reg.sv
module rsp_reg #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          finish,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic          done,
    output logic [DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= finish;
            if (capture) rdata <= dq_in;
        end
    end

    // R7: completion flag never lasts two cycles
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W            = 16,
    parameter int unsigned DATA_W            = 16,
    parameter int unsigned CLK_PERIOD_NS     = 10,
    parameter int unsigned T_CYCLE_NS        = 15,
    parameter int unsigned T_WE_PULSE_NS     = 12,
    parameter int unsigned T_DATA_SETUP_NS   = 8,
    parameter int unsigned T_ADDR_SETUP_NS   = 12,
    parameter int unsigned T_ADDR_ACCESS_NS  = 15,
    parameter int unsigned T_OE_ACCESS_NS    = 8,
    parameter int unsigned T_OE_FLOAT_NS     = 7,
    parameter int unsigned T_WE_FLOAT_NS     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe,
    output logic              sram_ce_n,
    output logic              sram_ce,
    output logic              sram_we_n,
    output logic              sram_oe_n
);
    // ---- phase lengths in cycles (R3) ----
    localparam int unsigned P     = CLK_PERIOD_NS;
    localparam int unsigned N_TA  = umax(ns_to_cyc(T_OE_FLOAT_NS, P), ns_to_cyc(T_WE_FLOAT_NS, P));
    localparam int unsigned N_WP  = umax(ns_to_cyc(T_WE_PULSE_NS, P),
                                         umax(ns_to_cyc(T_DATA_SETUP_NS, P), ns_to_cyc(T_ADDR_SETUP_NS, P)));
    localparam int unsigned N_WC  = ns_to_cyc(T_CYCLE_NS, P);
    localparam int unsigned N_WR  = (N_WC >= N_WP + 2) ? (N_WC - N_WP - 1) : 1;
    localparam int unsigned N_RA  = umax(umax(ns_to_cyc(T_ADDR_ACCESS_NS, P), ns_to_cyc(T_OE_ACCESS_NS, P)), N_WC);
    localparam int unsigned N_MAX = umax(umax(N_TA, N_WP), umax(N_WR, N_RA));
    localparam int unsigned TMR_W = (N_MAX < 2) ? 1 : $clog2(N_MAX);

    localparam logic [TMR_W-1:0] LD_TA = TMR_W'(N_TA - 1);
    localparam logic [TMR_W-1:0] LD_WP = TMR_W'(N_WP - 1);
    localparam logic [TMR_W-1:0] LD_WR = TMR_W'(N_WR - 1);
    localparam logic [TMR_W-1:0] LD_RA = TMR_W'(N_RA - 1);

    ctrl_state_t state_q, state_d;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              accept;
    logic              finish;
    logic              capture;
    logic              lat_write;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;

    phase_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    req_latch #(.AW(ADDR_W), .DW(DATA_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .in_write  (req_write),
        .in_addr   (req_addr),
        .in_wdata  (req_wdata),
        .out_write (lat_write),
        .out_addr  (lat_addr),
        .out_wdata (lat_wdata)
    );

    rsp_reg #(.DW(DATA_W)) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .finish  (finish),
        .capture (capture),
        .dq_in   (sram_dq_in),
        .done    (rsp_done),
        .rdata   (rsp_rdata)
    );

    // ---- state register ----
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---- next state and phase timer control ----
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        finish   = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write != lat_write) begin
                        state_d = ST_TURN;
                        tmr_val = LD_TA;
                    end else if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tmr_val = LD_RA;
                    end
                end
            end
            ST_TURN: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (lat_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tmr_val = LD_RA;
                    end
                end
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = LD_WP;
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    state_d  = ST_WR_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WR;
                end
            end
            ST_WR_RECOV: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                    capture = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---- strobe outputs, decoded from the state register ----
    logic en_act;
    always_comb begin
        req_ready  = 1'b0;
        en_act     = 1'b0;
        sram_we_n  = 1'b1;
        sram_oe_n  = 1'b1;
        sram_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_TURN:      ;
            ST_WR_SETUP:  begin en_act = 1'b1; sram_dq_oe = 1'b1; end
            ST_WR_PULSE:  begin en_act = 1'b1; sram_dq_oe = 1'b1; sram_we_n = 1'b0; end
            ST_WR_RECOV:  begin en_act = 1'b1; sram_dq_oe = 1'b1; end
            ST_RD_ACCESS: begin en_act = 1'b1; sram_oe_n = 1'b0; end
            default:      ;
        endcase
    end

    assign sram_ce_n   = ~en_act;
    assign sram_ce     = en_act;
    assign sram_addr   = lat_addr;
    assign sram_dq_out = lat_wdata;

    // ---- checks ----
    logic [7:0] we_low_cnt;
    localparam logic [7:0] WP_MIN = 8'(N_WP);
    always_ff @(posedge clk) begin
        if (!rst_n)                      we_low_cnt <= '0;
        else if (!sram_we_n)             we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 1'b1;
        else                             we_low_cnt <= '0;
    end

    p_we_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_ce && sram_oe_n));

    p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt >= WP_MIN));

    p_write_end_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_out)));

    p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_dq_oe && !sram_oe_n));

    p_drive_after_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> $past(sram_oe_n));

    p_idle_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && !sram_ce && sram_we_n && sram_oe_n));
endmodule

// File: tb/sim_sram_strobe_ctrl.sv
module sim_sram_strobe_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CLK = 10;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R3 counts from the requirement formulas
    localparam int C_TA = 1;
    localparam int C_WP = 2;
    localparam int C_WR = 1;
    localparam int C_RA = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          req_ready, rsp_done, sram_dq_oe, sram_ce_n, sram_ce, sram_we_n, sram_oe_n;
    logic [DW-1:0] rsp_rdata, sram_dq_out, sram_dq_in;
    logic [AW-1:0] sram_addr;

    sram_strobe_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe),
        .sram_ce_n(sram_ce_n), .sram_ce(sram_ce), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    int vectors = 0;
    int miscompares = 0;
    bit run_chk = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---- RAM model with interval checks ----
    logic [DW-1:0] ram [0:(1<<AW)-1];
    int oe_cnt = 0, a_cnt = 0, d_cnt = 0, we_cnt = 0;
    logic [AW-1:0] a_prev = '0;
    logic [DW-1:0] d_prev = '0;
    logic we_prev = 1'b1;

    initial begin
        for (int i = 0; i < (1 << AW); i++) ram[i] = 16'h0BAD;
        sram_dq_in = 16'hDEAD;
    end

    always @(negedge clk) begin
        if (we_prev == 1'b0 && sram_we_n) begin
            chk(we_cnt * CLK >= 12, "R4 we pulse ns", 32'(we_cnt * CLK), 32'd12);
            chk(d_cnt * CLK >= 8, "R4 data setup ns", 32'(d_cnt * CLK), 32'd8);
            chk(a_cnt * CLK >= 12, "R4 addr setup ns", 32'(a_cnt * CLK), 32'd12);
            chk(!sram_ce_n && sram_ce && sram_dq_oe && sram_dq_out == d_prev && sram_addr == a_prev,
                "R4 hold past write end", {sram_ce_n, sram_dq_oe}, 32'd1);
            ram[sram_addr] = d_prev;
        end
        a_cnt  = (sram_addr != a_prev) ? 1 : a_cnt + 1;
        d_cnt  = (sram_dq_out != d_prev || !sram_dq_oe) ? 1 : d_cnt + 1;
        oe_cnt = (!sram_ce_n && sram_ce && !sram_oe_n) ? oe_cnt + 1 : 0;
        we_cnt = (!sram_we_n) ? we_cnt + 1 : 0;
        a_prev = sram_addr;
        d_prev = sram_dq_out;
        we_prev = sram_we_n;
        sram_dq_in = (oe_cnt * CLK >= 8 && a_cnt * CLK >= 15) ? ram[sram_addr] : 16'hDEAD;
    end

    // ---- cycle-by-cycle reference model ----
    typedef struct packed {
        logic          ena;
        logic          we_n;
        logic          oe_n;
        logic          dq_oe;
        logic          last;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } exp_t;

    exp_t          exp_q[$];
    logic [DW-1:0] rdexp_q[$];
    logic [DW-1:0] shadow [0:(1<<AW)-1];
    bit model_last_wr = 0;
    bit done_due = 0;
    bit done_rd = 0;

    initial for (int i = 0; i < (1 << AW); i++) shadow[i] = 16'h0BAD;

    function automatic exp_t mk(input logic ena, input logic we_n, input logic oe_n, input logic dq,
                                input logic last, input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_t e;
        e.ena = ena; e.we_n = we_n; e.oe_n = oe_n; e.dq_oe = dq;
        e.last = last; e.rd = rd; e.addr = a; e.data = d;
        return e;
    endfunction

    always @(negedge clk) begin
        if (run_chk) begin
            exp_t e;
            bit busy;
            busy = (exp_q.size() != 0);
            e = busy ? exp_q.pop_front() : mk(0, 1, 1, 0, 0, 0, '0, '0);
            chk(req_ready == !busy, "R2 ready only when idle", {31'd0, req_ready}, {31'd0, !busy});
            chk({~sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe} == {e.ena, e.ena, e.we_n, e.oe_n, e.dq_oe},
                "R4 R6 R8 strobe pattern", {27'd0, ~sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe},
                {27'd0, e.ena, e.ena, e.we_n, e.oe_n, e.dq_oe});
            if (e.ena) chk(sram_addr == e.addr, "R4 R6 address", 32'(sram_addr), 32'(e.addr));
            if (e.dq_oe) chk(sram_dq_out == e.data, "R4 write data", 32'(sram_dq_out), 32'(e.data));
            chk(rsp_done == done_due, "R7 done pulse", {31'd0, rsp_done}, {31'd0, done_due});
            if (done_due && done_rd) begin
                logic [DW-1:0] x;
                x = rdexp_q.pop_front();
                chk(rsp_rdata == x, "R10 readback data", 32'(rsp_rdata), 32'(x));
            end
            done_due = busy && e.last;
            done_rd  = busy && e.last && e.rd;
            if (req_valid && req_ready) begin
                if (req_write != model_last_wr)
                    for (int i = 0; i < C_TA; i++) exp_q.push_back(mk(0, 1, 1, 0, 0, 0, req_addr, req_wdata));
                model_last_wr = req_write;
                if (req_write) begin
                    exp_q.push_back(mk(1, 1, 1, 1, 0, 0, req_addr, req_wdata));
                    for (int i = 0; i < C_WP; i++) exp_q.push_back(mk(1, 0, 1, 1, 0, 0, req_addr, req_wdata));
                    for (int i = 0; i < C_WR; i++)
                        exp_q.push_back(mk(1, 1, 1, 1, (i == C_WR - 1), 0, req_addr, req_wdata));
                    shadow[req_addr] = req_wdata;
                end else begin
                    for (int i = 0; i < C_RA; i++)
                        exp_q.push_back(mk(1, 1, 0, 0, (i == C_RA - 1), 1, req_addr, req_wdata));
                    rdexp_q.push_back(shadow[req_addr]);
                end
            end
        end
    end

    // ---- stimulus ----
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(200000 * CLK);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle outputs while in reset
        chk(req_ready && sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_done,
            "R1 reset state", {25'd0, req_ready, sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe, rsp_done},
            32'b1101100);
        @(posedge clk); #1;
        rst_n = 1'b1;
        run_chk = 1;
        gap(2);
        // R8: first write after reset takes a turnaround; R10 readback
        issue(1, 8'h10, 16'h1234);
        issue(0, 8'h10, 16'h0000);
        gap(3);
        // R10 boundary addresses and data
        issue(1, 8'h00, 16'h0000);
        issue(1, 8'hFF, 16'hFFFF);
        issue(0, 8'hFF, 16'h0);
        issue(0, 8'h00, 16'h0);
        // back-to-back writes then reads, no turnaround inside a run (R8)
        for (int i = 0; i < 8; i++) issue(1, 8'(8'h40 + i), 16'(16'hA500 + i));
        for (int i = 0; i < 8; i++) issue(0, 8'(8'h40 + i), 16'h0);
        // random write/readback with random gaps
        for (int i = 0; i < 60; i++) begin
            logic [AW-1:0] a;
            a = 8'($urandom);
            issue(1, a, 16'($urandom));
            if ($urandom % 3 == 0) gap(int'($urandom % 4));
            issue(0, a, 16'h0);
            if ($urandom % 2 == 0) issue(0, 8'($urandom), 16'h0);
        end
        gap(10);
        finish_run();
    end
endmodule